// File: doc/BRIEF.md
# I2C Byte-Memory Target

This block is an I2C target that fronts a 256-byte register array. It oversamples SCL and SDA on a fast system clock and finds START, repeated START and STOP from the synchronized lines. It answers a 7-bit device address made of a fixed `1010` prefix followed by three strap inputs. It pulls SDA low through an open-drain enable and never drives it high.

A single word pointer serves every access. A write transaction loads the pointer from its first byte. Each further byte is stored at the pointer, and the pointer then moves on by one. A read transaction returns the byte at the pointer and moves the pointer on. To read a chosen address, a controller first sends a write that carries only the word address. It then issues a repeated START and a read header. The read keeps streaming successive bytes for as long as the controller acknowledges. The read ends when the controller withholds its acknowledge and sends STOP.

Top module: `i2c_bytemem_target`

## Requirements
- R1: After reset, SDA is released (`sda_oe_o` = 0), the word pointer is 0, and every memory byte reads as 0x00.
- R2: The target acknowledges (pulls SDA low during the ninth clock) a header whose upper seven bits equal `1010` followed by `strap_i[2:0]`, MSB first. The header LSB selects the direction: 0 is write and 1 is read.
- R3: For a header that does not match, the target does not acknowledge. It keeps SDA released for the rest of the transfer, and no memory byte changes.
- R4: In a write, the first byte after the header is loaded into the word pointer. Each later byte is stored at the pointer, and the pointer then advances by one. The target acknowledges every one of these bytes.
- R5: A read header without a preceding address load returns the byte at the current pointer, MSB first, over the eight clocks after the header acknowledge. The pointer then advances by one.
- R6: A write header plus a word-address byte, followed by a repeated START and a read header, returns the byte at that word address.
- R7: If the controller acknowledges a read byte (SDA low in the ninth clock), the target sends the byte at the next address. The address wraps from 255 to 0.
- R8: When the controller withholds its acknowledge and sends STOP, the target releases SDA. The next transfer is then served normally.
- R9: The target changes `sda_oe_o` only while SCL is low.
- R10: A START arriving partway through a byte abandons that byte, storing nothing, and returns the target to the header phase.
- R11: In a write, the pointer wraps from 255 to 0, so a write burst that starts at 0xFE fills 0xFE, 0xFF and then 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_i | input | 3 | Low three bits of the device address |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The bench aims at the places where the pointer can be off by one. These are the current-address read after a write burst, the read that follows an address-only write, and the two wraps at 255. A design that advanced the pointer at the wrong moment would return the neighbouring byte there. A START is injected four bits into a data byte. A design that did not abandon that byte would corrupt memory or start its reply at the wrong address. A wrong strap header is sent with trailing data. A design that did not fall silent after the mismatch would acknowledge or write. The bench also watches SDA against SCL on every cycle, so a release made while SCL is high is caught.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

  localparam int BYTE_W   = 8;
  localparam int PREFIX_W = 4;
  localparam int STRAP_W  = 3;
  localparam logic [PREFIX_W-1:0] DEV_PREFIX = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEVADDR,
    ST_DEVACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDACK,
    ST_IGNORE
  } tgt_state_e;

  // Header match: seven received address bits against prefix plus straps.
  function automatic logic addr_hit(input logic [BYTE_W-2:0] rx,
                                    input logic [STRAP_W-1:0] strap);
    return rx == {DEV_PREFIX, strap};
  endfunction

endpackage

// File: rtl/i2c_bus_front.sv
module i2c_bus_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[SYNC_STAGES-1];
      sda_q    <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[SYNC_STAGES-1];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_byte_store.sv
module i2c_byte_store
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cells[g] <= '0;
      else if (we && addr == ADDR_W'(g)) cells[g] <= wdata;
    end
  end

  assign rdata = cells[addr];

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [STRAP_W-1:0] strap,
  input  logic [BYTE_W-1:0]  rdata,
  output logic               sda_oe,
  output logic               mem_we,
  output logic               rd_load,
  output logic [ADDR_W-1:0]  ptr,
  output logic [BYTE_W-1:0]  wdata,
  output tgt_state_e         state
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic              rw;
  logic              host_ack;
  logic              byte_end;

  assign byte_end = scl_fall && (bitcnt == FULL);
  assign mem_we   = (state == ST_WDATA) && byte_end && !start_det && !stop_det;
  assign rd_load  = !start_det && !stop_det && scl_fall &&
                    (((state == ST_DEVACK) && rw) ||
                     ((state == ST_RDACK) && bitcnt == CNT_W'(1) && host_ack));
  assign wdata    = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      sda_oe   <= 1'b0;
      ptr      <= '0;
      rw       <= 1'b0;
      host_ack <= 1'b0;
    end else if (start_det) begin
      state  <= ST_DEVADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (rd_load) begin
      shreg  <= rdata;
      sda_oe <= ~rdata[BYTE_W-1];
      ptr    <= ptr + 1'b1;
      bitcnt <= '0;
      state  <= ST_RDATA;
    end else begin
      unique case (state)
        ST_DEVADDR, ST_WADDR, ST_WDATA: begin
          if (scl_rise) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_end) begin
            if (state == ST_DEVADDR) begin
              if (addr_hit(shreg[BYTE_W-1:1], strap)) begin
                sda_oe <= 1'b1;
                rw     <= shreg[0];
                state  <= ST_DEVACK;
              end else begin
                state <= ST_IGNORE;
              end
            end else if (state == ST_WADDR) begin
              ptr    <= shreg[ADDR_W-1:0];
              sda_oe <= 1'b1;
              state  <= ST_WADDR_ACK;
            end else begin
              ptr    <= ptr + 1'b1;
              sda_oe <= 1'b1;
              state  <= ST_WDATA_ACK;
            end
          end
        end
        ST_DEVACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            state  <= ST_WADDR;
          end
        end
        ST_WADDR_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            state  <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_end) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            state  <= ST_RDACK;
          end else if (scl_fall && bitcnt != '0) begin
            shreg  <= {shreg[BYTE_W-2:0], 1'b0};
            sda_oe <= ~shreg[BYTE_W-2];
          end
        end
        ST_RDACK: begin
          if (scl_rise) begin
            host_ack <= ~sda_s;
            bitcnt   <= CNT_W'(1);
          end else if (scl_fall && bitcnt == CNT_W'(1)) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            state  <= ST_IGNORE;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_bytemem_target.sv
module i2c_bytemem_target
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_oe_o
);

  logic              scl_s, sda_s, scl_rise, scl_fall;
  logic              start_det, stop_det;
  logic              mem_we, rd_load;
  logic [ADDR_W-1:0] ptr;
  logic [BYTE_W-1:0] wdata, rdata;
  tgt_state_e        fsm_state;

  i2c_bus_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_target_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .strap     (strap_i),
    .rdata     (rdata),
    .sda_oe    (sda_oe_o),
    .mem_we    (mem_we),
    .rd_load   (rd_load),
    .ptr       (ptr),
    .wdata     (wdata),
    .state     (fsm_state)
  );

  i2c_byte_store #(.ADDR_W(ADDR_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .addr  (ptr),
    .wdata (wdata),
    .rdata (rdata)
  );

endmodule

// File: rtl/i2c_bytemem_checker.sv
module i2c_bytemem_checker
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              sda_oe,
  input logic              start_det,
  input logic              stop_det,
  input tgt_state_e        state,
  input logic              mem_we,
  input logic              rd_load,
  input logic [ADDR_W-1:0] ptr
);

  p_ignore_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE) |-> !sda_oe);

  p_write_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (ptr == $past(ptr) + 1'b1));

  p_read_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |=> (ptr == $past(ptr) + 1'b1));

  p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  p_start_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_DEVADDR));

endmodule

bind i2c_bytemem_target i2c_bytemem_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .sda_oe    (sda_oe_o),
  .start_det (start_det),
  .stop_det  (stop_det),
  .state     (fsm_state),
  .mem_we    (mem_we),
  .rd_load   (rd_load),
  .ptr       (ptr)
);

// File: tb/i2c_bytemem_target_tb.sv
module i2c_bytemem_target_tb;

  localparam int Q = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [2:0] strap = 3'b010;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  int oe_seen = 0;
  int r9_viol = 0;
  logic oe_prev = 1'b0;
  logic [7:0] got;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  event       ev_byte;

  always #4 clk = ~clk;

  i2c_bytemem_target u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .strap_i  (strap),
    .sda_oe_o (sda_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // R9 watch and mismatch-silence tracking
  always @(negedge clk) begin
    if (rst_n && sda_oe != oe_prev && scl_m) r9_viol++;
    if (sda_oe) oe_seen++;
    oe_prev <= sda_oe;
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(ev_byte);
      if (exp_q.size() == 0) begin
        chk(1'b0, "unexpected byte", got, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(got == e, t, got, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic clk_bit(input bit v);
    sda_m = v; tick(Q);
    scl_m = 1'b1; tick(Q);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) clk_bit(b[i]);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q / 2);
    ack = !sda_line;
    tick(Q / 2);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic recv_byte(input bit host_ack);
    logic [7:0] b;
    b = '0;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      scl_m = 1'b1; tick(Q / 2);
      b = {b[6:0], sda_line};
      tick(Q / 2);
      scl_m = 1'b0; tick(2);
    end
    got = b;
    -> ev_byte;
    clk_bit(!host_ack);
    sda_m = 1'b1;
  endtask

  task automatic expect_read(input logic [7:0] e, input bit host_ack, input string req);
    exp_q.push_back(e);
    tag_q.push_back(req);
    recv_byte(host_ack);
  endtask

  task automatic header(input bit rw, input string req);
    bit a;
    bus_start();
    send_byte({4'b1010, strap, rw}, a);
    chk(a, req, a, 1);
  endtask

  task automatic data_out(input logic [7:0] b, input string req);
    bit a;
    send_byte(b, a);
    chk(a, req, a, 1);
  endtask

  task automatic stop_check();
    bus_stop();
    tick(4);
    chk(sda_oe == 1'b0, "R8 release after stop", sda_oe, 0);
  endtask

  initial begin
    bit a;
    tick(10);
    chk(sda_oe == 1'b0, "R1 reset release", sda_oe, 0);
    rst_n = 1'b1;
    tick(10);

    // R1/R5: current-address read right after reset
    header(1'b1, "R2 header ack");
    expect_read(8'h00, 1'b0, "R1 reset content at pointer 0");
    stop_check();

    // R3: wrong straps, trailing bytes ignored
    oe_seen = 0;
    bus_start();
    send_byte({4'b1010, 3'b101, 1'b0}, a);
    chk(!a, "R3 no ack on mismatch", a, 0);
    send_byte(8'h10, a);
    send_byte(8'h55, a);
    bus_stop();
    chk(oe_seen == 0, "R3 SDA stays released", oe_seen, 0);

    // R4: burst write at 0x20
    header(1'b0, "R4 write header");
    data_out(8'h20, "R4 word address ack");
    data_out(8'h11, "R4 data ack");
    data_out(8'h22, "R4 data ack");
    data_out(8'h33, "R4 data ack");
    stop_check();

    // R3 confirm: 0x10 untouched
    header(1'b0, "R6 dummy write");
    data_out(8'h10, "R6 address ack");
    header(1'b1, "R6 read header");
    expect_read(8'h00, 1'b0, "R3 mismatch wrote nothing");
    stop_check();

    // R6: random read
    header(1'b0, "R6 dummy write");
    data_out(8'h20, "R6 address ack");
    header(1'b1, "R6 read header");
    expect_read(8'h11, 1'b0, "R6 random read");
    stop_check();

    // R5: current-address reads continue after 0x20
    header(1'b1, "R5 header");
    expect_read(8'h22, 1'b0, "R5 current-address read");
    stop_check();
    header(1'b1, "R5 header");
    expect_read(8'h33, 1'b0, "R5 current-address read");
    stop_check();

    // R7: sequential read
    header(1'b0, "R7 dummy write");
    data_out(8'h20, "R7 address ack");
    header(1'b1, "R7 read header");
    expect_read(8'h11, 1'b1, "R7 seq byte 0");
    expect_read(8'h22, 1'b1, "R7 seq byte 1");
    expect_read(8'h33, 1'b0, "R7 seq byte 2");
    stop_check();

    // R11: write wraps 0xFF -> 0x00
    header(1'b0, "R11 write header");
    data_out(8'hFE, "R11 address ack");
    data_out(8'hA5, "R11 data ack");
    data_out(8'hB6, "R11 data ack");
    data_out(8'hC7, "R11 data ack");
    stop_check();
    header(1'b1, "R11 header");
    expect_read(8'h00, 1'b0, "R11 pointer at 0x01 after wrap");
    stop_check();

    // R7: read wraps 0xFF -> 0x00
    header(1'b0, "R7 dummy write");
    data_out(8'hFE, "R7 address ack");
    header(1'b1, "R7 read header");
    expect_read(8'hA5, 1'b1, "R7 wrap byte 0xFE");
    expect_read(8'hB6, 1'b1, "R7 wrap byte 0xFF");
    expect_read(8'hC7, 1'b0, "R7 wrap byte 0x00");
    tick(4);
    chk(sda_oe == 1'b0, "R8 release after host nack", sda_oe, 0);
    stop_check();

    // R10: START four bits into a data byte
    header(1'b0, "R10 write header");
    data_out(8'h40, "R10 address ack");
    data_out(8'h77, "R10 data ack");
    stop_check();
    header(1'b0, "R10 write header");
    data_out(8'h40, "R10 address ack");
    for (int i = 0; i < 4; i++) clk_bit(1'b0);
    header(1'b1, "R10 header after mid-byte start");
    expect_read(8'h77, 1'b1, "R10 byte not overwritten");
    expect_read(8'h00, 1'b0, "R10 pointer not advanced");
    stop_check();

    // R2: new straps; old address no longer answers
    strap = 3'b111;
    tick(4);
    header(1'b1, "R2 new strap ack");
    expect_read(8'h00, 1'b0, "R8 transfer after stop");
    stop_check();
    bus_start();
    send_byte({4'b1010, 3'b010, 1'b1}, a);
    chk(!a, "R2 old strap rejected", a, 0);
    bus_stop();

    tick(20);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    chk(r9_viol == 0, "R9 SDA changes only with SCL low", r9_viol, 0);
    finish_run();
  end

endmodule